// File: doc/BRIEF.md
# Programmable Parallel Display Bus Timer

This block drives one bus cycle at a time on an 8080-style parallel bus. The far end is a display controller that keeps its own frame memory. A simple front end hands the block a request: a command write, a parameter write or a read. The block answers with a valid/ready handshake. Once a request is accepted, a tick counter runs from zero. Chip select, write strobe and read strobe are each low between their own programmed assert tick and deassert tick. The cycle ends when the counter reaches the programmed length. Writes and reads each have their own length.

A configuration bit picks the tick period: one clock or two clocks. On a read, the block releases the data bus. It registers the input at the end of the programmed access tick and gives a one-clock done pulse once the cycle is over. The bus carries 8 or 16 bits per cycle, chosen by a 2-bit width field. All timing fields are captured when a request is accepted, so a cycle runs on the values it started with.

Top module: `pbus_timer`

## Requirements
- R1: After reset, and whenever no cycle runs, all three strobes are high (released), D/C is high, the data output enable is low, busy is low, ready is high and the done pulse is low.
- R2: In every cycle, chip select is low exactly during the ticks t with cs_on <= t < cs_off, with ticks counted from 0 at the first clock after acceptance.
- R3: In command and parameter cycles, the write strobe is low exactly for ticks we_on <= t < we_off. In read cycles it stays high.
- R4: In read cycles, the read strobe is low exactly for ticks re_on <= t < re_off. In write cycles it stays high.
- R5: A write cycle (kind 0, 1 or 3) lasts wr_len ticks and a read cycle (kind 2) lasts rd_len ticks. Busy is high and ready is low for exactly that span.
- R6: With the half-rate bit clear, a tick is one clock. With it set, a tick is two clocks, and every edge position and cycle length doubles in clocks.
- R7: D/C is low for the whole of a command cycle (kind 0) and high for the whole of parameter (kind 1 or 3) and read (kind 2) cycles.
- R8: In write cycles the output enable is high for the whole cycle and the bus carries the request data. In read cycles the output enable is low.
- R9: A read registers the bus input at the end of the tick equal to the sample field. That value appears on rd_data together with a one-clock rd_done pulse in the first clock after the cycle, and it holds until the next read.
- R10: Width field value 3 selects 16-bit transfers. Any other value selects 8-bit transfers, in which the upper byte of the driven data and of rd_data is zero.
- R11: A request offered while a cycle runs is not accepted. It is held and accepted, with its own kind and data, in the clock after that cycle ends.
- R12: Changing any configuration input during a cycle has no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_half_rate | input | 1 | 1: one tick is two clocks |
| cfg_bus_width | input | 2 | 3: 16-bit, other values: 8-bit |
| cfg_cs_on | input | ON_W | Chip-select assert tick |
| cfg_cs_off | input | OFF_W | Chip-select release tick |
| cfg_we_on | input | ON_W | Write-strobe assert tick |
| cfg_we_off | input | OFF_W | Write-strobe release tick |
| cfg_re_on | input | ON_W | Read-strobe assert tick |
| cfg_re_off | input | OFF_W | Read-strobe release tick |
| cfg_wr_len | input | OFF_W | Write cycle length in ticks |
| cfg_rd_len | input | OFF_W | Read cycle length in ticks |
| cfg_sample | input | OFF_W | Read sample tick |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_kind | input | 2 | 0 command, 1 parameter, 2 read, 3 parameter |
| req_data | input | DATA_W | Write data |
| busy | output | 1 | A cycle is running |
| rd_done | output | 1 | One-clock pulse after a read cycle |
| rd_data | output | DATA_W | Last sampled read value |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_re_n | output | 1 | Read strobe, active low |
| bus_dc | output | 1 | Data/command select, low for commands |
| bus_dq_out | output | DATA_W | Data driven to the bus |
| bus_dq_oe | output | 1 | Output enable for bus_dq_out |
| bus_dq_in | input | DATA_W | Data read from the bus |

## Verification
Command, parameter and read cycles run under one timing set, so each strobe and D/C can be checked against the request kind that should enable it. The same pattern is repeated at half rate with different edge values. This separates a doubled tick from a shifted window, and shows whether the read sample lands on the right tick, since the bus input is given a different value on every tick. An 8-bit pass with wide data exposes upper-byte leaks in either direction. A request offered mid-cycle, and configuration changed mid-cycle, show that pending work is neither dropped nor corrupted and that a running cycle keeps its captured timing.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
   typedef enum logic [1:0] {
      KIND_CMD   = 2'd0,
      KIND_PARAM = 2'd1,
      KIND_READ  = 2'd2,
      KIND_ALT   = 2'd3
   } req_kind_e;

   localparam logic [1:0] WIDTH_WIDE = 2'd3;
   localparam int         N_STROBES  = 3;
   localparam int         S_CS       = 0;
   localparam int         S_WE       = 1;
   localparam int         S_RE       = 2;
endpackage

// File: rtl/pbus_tick_gen.sv
module pbus_tick_gen #(
   parameter bit HALF_RATE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   input  logic half,
   output logic tick
);
   generate
      if (HALF_RATE_EN) begin : g_div
         logic phase;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       phase <= 1'b0;
            else if (restart) phase <= 1'b0;
            else if (run)     phase <= ~phase;
         end
         assign tick = run && (!half || phase);
      end else begin : g_nodiv
         logic unused_half;
         assign unused_half = half & restart;
         assign tick = run;
      end
   endgenerate
endmodule

// File: rtl/pbus_window.sv
module pbus_window #(
   parameter int ON_W  = 4,
   parameter int OFF_W = 6
) (
   input  logic             enable,
   input  logic [OFF_W-1:0] count,
   input  logic [ON_W-1:0]  on_tick,
   input  logic [OFF_W-1:0] off_tick,
   output logic             strobe_n
);
   localparam int PAD = OFF_W - ON_W;
   logic [OFF_W-1:0] on_ext;
   assign on_ext   = {{PAD{1'b0}}, on_tick};
   assign strobe_n = !(enable && (count >= on_ext) && (count < off_tick));
endmodule

// File: rtl/pbus_cycle_ctrl.sv
module pbus_cycle_ctrl
   import pbus_pkg::*;
#(
   parameter int ON_W   = 4,
   parameter int OFF_W  = 6,
   parameter int DATA_W = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cfg_half_rate,
   input  logic [1:0]                   cfg_bus_width,
   input  logic [N_STROBES-1:0][ON_W-1:0]  cfg_on,
   input  logic [N_STROBES-1:0][OFF_W-1:0] cfg_off,
   input  logic [OFF_W-1:0]             cfg_wr_len,
   input  logic [OFF_W-1:0]             cfg_rd_len,
   input  logic [OFF_W-1:0]             cfg_sample,
   input  logic                         req_valid,
   input  logic [1:0]                   req_kind,
   input  logic [DATA_W-1:0]            req_data,
   input  logic [DATA_W-1:0]            dq_in,
   input  logic                         tick,
   output logic                         accept,
   output logic                         busy,
   output logic                         half_q,
   output logic [OFF_W-1:0]             count,
   output logic [N_STROBES-1:0][ON_W-1:0]  on_q,
   output logic [N_STROBES-1:0][OFF_W-1:0] off_q,
   output req_kind_e                    kind_q,
   output logic [DATA_W-1:0]            data_q,
   output logic [DATA_W-1:0]            rd_data,
   output logic                         rd_done
);
   localparam int HALF_W = DATA_W / 2;

   logic             wide_q;
   logic [OFF_W-1:0] len_q;
   logic [OFF_W-1:0] sample_q;
   logic [OFF_W:0]   count_next;
   logic             is_read;
   logic             req_wide;
   logic [DATA_W-1:0] req_masked;
   logic [DATA_W-1:0] in_masked;

   assign accept     = req_valid && !busy;
   assign is_read    = (kind_q == KIND_READ);
   assign count_next = {1'b0, count} + 1'b1;
   assign req_wide   = (cfg_bus_width == WIDTH_WIDE);
   assign req_masked = req_wide ? req_data : {{HALF_W{1'b0}}, req_data[HALF_W-1:0]};
   assign in_masked  = wide_q ? dq_in : {{HALF_W{1'b0}}, dq_in[HALF_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         count    <= '0;
         half_q   <= 1'b0;
         wide_q   <= 1'b0;
         on_q     <= '0;
         off_q    <= '0;
         len_q    <= '0;
         sample_q <= '0;
         kind_q   <= KIND_CMD;
         data_q   <= '0;
         rd_data  <= '0;
         rd_done  <= 1'b0;
      end else begin
         rd_done <= 1'b0;
         if (accept) begin
            busy     <= 1'b1;
            count    <= '0;
            half_q   <= cfg_half_rate;
            wide_q   <= req_wide;
            on_q     <= cfg_on;
            off_q    <= cfg_off;
            len_q    <= (req_kind == KIND_READ) ? cfg_rd_len : cfg_wr_len;
            sample_q <= cfg_sample;
            kind_q   <= req_kind_e'(req_kind);
            data_q   <= req_masked;
         end else if (busy && tick) begin
            if (is_read && (count == sample_q)) rd_data <= in_masked;
            if (count_next >= {1'b0, len_q}) begin
               busy    <= 1'b0;
               count   <= '0;
               rd_done <= is_read;
            end else begin
               count <= count_next[OFF_W-1:0];
            end
         end
      end
   end
endmodule

// File: rtl/pbus_timer.sv
module pbus_timer
   import pbus_pkg::*;
#(
   parameter int ON_W         = 4,
   parameter int OFF_W        = 6,
   parameter int DATA_W       = 16,
   parameter bit HALF_RATE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_half_rate,
   input  logic [1:0]        cfg_bus_width,
   input  logic [ON_W-1:0]   cfg_cs_on,
   input  logic [OFF_W-1:0]  cfg_cs_off,
   input  logic [ON_W-1:0]   cfg_we_on,
   input  logic [OFF_W-1:0]  cfg_we_off,
   input  logic [ON_W-1:0]   cfg_re_on,
   input  logic [OFF_W-1:0]  cfg_re_off,
   input  logic [OFF_W-1:0]  cfg_wr_len,
   input  logic [OFF_W-1:0]  cfg_rd_len,
   input  logic [OFF_W-1:0]  cfg_sample,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic [DATA_W-1:0] req_data,
   output logic              busy,
   output logic              rd_done,
   output logic [DATA_W-1:0] rd_data,
   output logic              bus_cs_n,
   output logic              bus_we_n,
   output logic              bus_re_n,
   output logic              bus_dc,
   output logic [DATA_W-1:0] bus_dq_out,
   output logic              bus_dq_oe,
   input  logic [DATA_W-1:0] bus_dq_in
);
   generate
      if (ON_W < 1 || ON_W > OFF_W) begin : g_bad_on
         $error("pbus_timer: ON_W must be in 1..OFF_W");
      end
      if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_data
         $error("pbus_timer: DATA_W must be even and at least 2");
      end
   endgenerate

   logic [N_STROBES-1:0][ON_W-1:0]  cfg_on;
   logic [N_STROBES-1:0][OFF_W-1:0] cfg_off;
   logic [N_STROBES-1:0][ON_W-1:0]  on_q;
   logic [N_STROBES-1:0][OFF_W-1:0] off_q;
   logic [N_STROBES-1:0]            win_en;
   logic [N_STROBES-1:0]            win_n;
   logic [OFF_W-1:0]                count;
   logic                            accept;
   logic                            half_q;
   logic                            tick;
   req_kind_e                       kind_q;
   logic [DATA_W-1:0]               data_q;
   logic                            is_read;

   assign cfg_on[S_CS]  = cfg_cs_on;
   assign cfg_on[S_WE]  = cfg_we_on;
   assign cfg_on[S_RE]  = cfg_re_on;
   assign cfg_off[S_CS] = cfg_cs_off;
   assign cfg_off[S_WE] = cfg_we_off;
   assign cfg_off[S_RE] = cfg_re_off;

   pbus_cycle_ctrl #(.ON_W(ON_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_half_rate (cfg_half_rate),
      .cfg_bus_width (cfg_bus_width),
      .cfg_on        (cfg_on),
      .cfg_off       (cfg_off),
      .cfg_wr_len    (cfg_wr_len),
      .cfg_rd_len    (cfg_rd_len),
      .cfg_sample    (cfg_sample),
      .req_valid     (req_valid),
      .req_kind      (req_kind),
      .req_data      (req_data),
      .dq_in         (bus_dq_in),
      .tick          (tick),
      .accept        (accept),
      .busy          (busy),
      .half_q        (half_q),
      .count         (count),
      .on_q          (on_q),
      .off_q         (off_q),
      .kind_q        (kind_q),
      .data_q        (data_q),
      .rd_data       (rd_data),
      .rd_done       (rd_done)
   );

   pbus_tick_gen #(.HALF_RATE_EN(HALF_RATE_EN)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (accept),
      .run     (busy),
      .half    (half_q),
      .tick    (tick)
   );

   assign is_read      = (kind_q == KIND_READ);
   assign win_en[S_CS] = busy;
   assign win_en[S_WE] = busy && !is_read;
   assign win_en[S_RE] = busy && is_read;

   generate
      for (genvar s = 0; s < N_STROBES; s++) begin : g_win
         pbus_window #(.ON_W(ON_W), .OFF_W(OFF_W)) u_win (
            .enable   (win_en[s]),
            .count    (count),
            .on_tick  (on_q[s]),
            .off_tick (off_q[s]),
            .strobe_n (win_n[s])
         );
      end
   endgenerate

   assign bus_cs_n   = win_n[S_CS];
   assign bus_we_n   = win_n[S_WE];
   assign bus_re_n   = win_n[S_RE];
   assign bus_dc     = !(busy && kind_q == KIND_CMD);
   assign bus_dq_oe  = busy && !is_read;
   assign bus_dq_out = data_q;
   assign req_ready  = !busy;
endmodule

// File: rtl/pbus_timer_chk.sv
module pbus_timer_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic busy,
   input logic rd_done,
   input logic bus_cs_n,
   input logic bus_we_n,
   input logic bus_re_n,
   input logic bus_dc,
   input logic bus_dq_oe
);
   p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (bus_cs_n && bus_we_n && bus_re_n && bus_dc && !bus_dq_oe));

   p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_we_n && !bus_re_n));

   p_dc_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(bus_dc));

   p_oe_not_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_dq_oe |-> bus_re_n);

   p_done_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |-> (!busy && $past(busy)));

   p_accept_starts_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> busy);
endmodule

bind pbus_timer pbus_timer_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .busy      (busy),
   .rd_done   (rd_done),
   .bus_cs_n  (bus_cs_n),
   .bus_we_n  (bus_we_n),
   .bus_re_n  (bus_re_n),
   .bus_dc    (bus_dc),
   .bus_dq_oe (bus_dq_oe)
);

// File: tb/tb_pbus_timer.sv
module tb_pbus_timer;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_half_rate = 1'b0;
   logic [1:0]  cfg_bus_width = 2'd3;
   logic [3:0]  cfg_cs_on = '0, cfg_we_on = '0, cfg_re_on = '0;
   logic [5:0]  cfg_cs_off = '0, cfg_we_off = '0, cfg_re_off = '0;
   logic [5:0]  cfg_wr_len = '0, cfg_rd_len = '0, cfg_sample = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_kind = '0;
   logic [15:0] req_data = '0;
   logic        busy, rd_done;
   logic [15:0] rd_data;
   logic        bus_cs_n, bus_we_n, bus_re_n, bus_dc, bus_dq_oe;
   logic [15:0] bus_dq_out;
   logic [15:0] bus_dq_in = '0;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pbus_timer dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_half_rate(cfg_half_rate), .cfg_bus_width(cfg_bus_width),
      .cfg_cs_on(cfg_cs_on), .cfg_cs_off(cfg_cs_off),
      .cfg_we_on(cfg_we_on), .cfg_we_off(cfg_we_off),
      .cfg_re_on(cfg_re_on), .cfg_re_off(cfg_re_off),
      .cfg_wr_len(cfg_wr_len), .cfg_rd_len(cfg_rd_len), .cfg_sample(cfg_sample),
      .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
      .req_data(req_data), .busy(busy), .rd_done(rd_done), .rd_data(rd_data),
      .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n), .bus_re_n(bus_re_n),
      .bus_dc(bus_dc), .bus_dq_out(bus_dq_out), .bus_dq_oe(bus_dq_oe),
      .bus_dq_in(bus_dq_in)
   );

   task automatic check(input string req, input bit ok, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] width_mask(input logic [15:0] d, input logic [1:0] w);
      return (w == 2'd3) ? d : {8'h00, d[7:0]};
   endfunction

   task automatic set_timing(input int cs_on, cs_off, we_on, we_off, re_on, re_off,
                             wr_len, rd_len, sample, input bit half, input logic [1:0] w);
      cfg_cs_on = 4'(cs_on);  cfg_cs_off = 6'(cs_off);
      cfg_we_on = 4'(we_on);  cfg_we_off = 6'(we_off);
      cfg_re_on = 4'(re_on);  cfg_re_off = 6'(re_off);
      cfg_wr_len = 6'(wr_len); cfg_rd_len = 6'(rd_len); cfg_sample = 6'(sample);
      cfg_half_rate = half; cfg_bus_width = w;
   endtask

   // One full bus cycle; every output is compared on every clock (R2..R10, R12 when mutate)
   task automatic run_cycle(input logic [1:0] kind, input logic [15:0] data, input bit mutate);
      int csn, cso, wen, weo, ren, reo, len, smp, dv, n;
      int cs_bad = 0, we_bad = 0, re_bad = 0, dc_bad = 0, oe_bad = 0, bz_bad = 0, dq_bad = 0;
      logic [1:0] w;
      bit rd, exp_cs, exp_we, exp_re;
      logic [15:0] exp_rd;
      csn = cfg_cs_on; cso = cfg_cs_off; wen = cfg_we_on; weo = cfg_we_off;
      ren = cfg_re_on; reo = cfg_re_off; smp = cfg_sample; w = cfg_bus_width;
      rd  = (kind == 2'd2);
      len = rd ? int'(cfg_rd_len) : int'(cfg_wr_len);
      dv  = cfg_half_rate ? 2 : 1;
      n   = len * dv;
      exp_rd = width_mask(16'hA500 | 16'(smp), w);
      @(negedge clk);
      req_valid = 1'b1; req_kind = kind; req_data = data;
      @(posedge clk);
      for (int i = 0; i < n; i++) begin
         int t;
         @(negedge clk);
         if (i == 0) begin
            req_valid = 1'b0;
            if (mutate) set_timing(0, 1, 0, 1, 0, 1, 1, 1, 0, ~cfg_half_rate, 2'd0);
         end
         t = i / dv;
         bus_dq_in = 16'hA500 | 16'(t);
         exp_cs = (t >= csn) && (t < cso);
         exp_we = !rd && (t >= wen) && (t < weo);
         exp_re = rd && (t >= ren) && (t < reo);
         if (bus_cs_n !== !exp_cs) cs_bad++;
         if (bus_we_n !== !exp_we) we_bad++;
         if (bus_re_n !== !exp_re) re_bad++;
         if (bus_dc !== (kind != 2'd0)) dc_bad++;
         if (bus_dq_oe !== !rd) oe_bad++;
         if (busy !== 1'b1 || req_ready !== 1'b0) bz_bad++;
         if (!rd && bus_dq_out !== width_mask(data, w)) dq_bad++;
      end
      check(mutate ? "R12 cs window" : "R2 cs window",  cs_bad == 0, cs_bad, 0);
      check(mutate ? "R12 we window" : "R3 we window",  we_bad == 0, we_bad, 0);
      check(mutate ? "R12 re window" : "R4 re window",  re_bad == 0, re_bad, 0);
      check("R7 dc level", dc_bad == 0, dc_bad, 0);
      check("R8 output enable", oe_bad == 0, oe_bad, 0);
      check(dv == 2 ? "R6 busy span half rate" : "R5 busy span", bz_bad == 0, bz_bad, 0);
      if (!rd) check(w == 2'd3 ? "R8 write data" : "R10 write data narrow",
                     dq_bad == 0, dq_bad, 0);
      @(negedge clk);
      check(dv == 2 ? "R6 cycle end" : "R5 cycle end", busy == 1'b0 && req_ready == 1'b1,
            {busy, req_ready}, 2'b01);
      check("R9 done pulse", rd_done == rd, rd_done, rd);
      if (rd) check(w == 2'd3 ? "R9 read sample" : "R10 read sample narrow",
                    rd_data == exp_rd, rd_data, exp_rd);
      @(negedge clk);
      check("R9 done single clock", rd_done == 1'b0, rd_done, 0);
      if (rd) check("R9 read data holds", rd_data == exp_rd, rd_data, exp_rd);
   endtask

   task automatic test_reset();
      check("R1 idle strobes", {bus_cs_n, bus_we_n, bus_re_n, bus_dc} == 4'hF,
            {bus_cs_n, bus_we_n, bus_re_n, bus_dc}, 4'hF);
      check("R1 idle handshake", {busy, req_ready, rd_done, bus_dq_oe} == 4'b0100,
            {busy, req_ready, rd_done, bus_dq_oe}, 4'b0100);
      check("R1 read data reset", rd_data == 16'h0, rd_data, 0);
   endtask

   task automatic test_stall();
      int guard = 0;
      set_timing(0, 6, 1, 4, 1, 5, 6, 6, 2, 1'b0, 2'd3);
      @(negedge clk);
      req_valid = 1'b1; req_kind = 2'd1; req_data = 16'h1111;
      @(posedge clk);
      @(negedge clk);
      req_kind = 2'd0; req_data = 16'h2222;
      check("R11 not ready while busy", req_ready == 1'b0 && busy == 1'b1,
            {req_ready, busy}, 2'b01);
      check("R11 first data kept", bus_dq_out == 16'h1111, bus_dq_out, 16'h1111);
      while (busy && guard < 100) begin
         @(negedge clk);
         guard++;
      end
      check("R11 ready after cycle", req_ready == 1'b1, req_ready, 1);
      @(negedge clk);
      check("R11 held request taken", busy == 1'b1 && bus_dq_out == 16'h2222 && bus_dc == 1'b0,
            {busy, bus_dq_out, bus_dc}, {1'b1, 16'h2222, 1'b0});
      req_valid = 1'b0;
      guard = 0;
      while (busy && guard < 100) begin
         @(negedge clk);
         guard++;
      end
      check("R11 second cycle ends", busy == 1'b0, busy, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      // 16-bit, one clock per tick
      set_timing(0, 8, 2, 6, 3, 7, 9, 10, 5, 1'b0, 2'd3);
      run_cycle(2'd0, 16'h1234, 1'b0);
      run_cycle(2'd1, 16'hC3A5, 1'b0);
      run_cycle(2'd2, 16'h0000, 1'b0);
      run_cycle(2'd3, 16'h5AF0, 1'b0);
      // half rate, different edges
      set_timing(1, 7, 3, 5, 2, 6, 7, 8, 4, 1'b1, 2'd3);
      run_cycle(2'd1, 16'h7E81, 1'b0);
      run_cycle(2'd2, 16'h0000, 1'b0);
      // 8-bit width
      set_timing(0, 5, 1, 4, 1, 5, 5, 6, 3, 1'b0, 2'd0);
      run_cycle(2'd1, 16'hBEEF, 1'b0);
      run_cycle(2'd2, 16'h0000, 1'b0);
      // configuration altered mid-cycle
      set_timing(2, 9, 3, 7, 3, 8, 9, 9, 6, 1'b0, 2'd3);
      run_cycle(2'd2, 16'h0000, 1'b1);
      set_timing(2, 9, 3, 7, 3, 8, 9, 9, 6, 1'b1, 2'd3);
      run_cycle(2'd0, 16'h9ABC, 1'b1);
      test_stall();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule